// File: doc/BRIEF.md
# Keepalive-Aware Receive Reason Classifier

This block sits on the host receive path behind a flow offload engine. Each frame that the engine hands to the host carries a 32-bit descriptor word. The word holds a flow-table index and a five-bit reason code. The classifier decodes the word and makes one decision per descriptor: the frame is either delivered to the host network stack or consumed. Keepalive reasons are consumed. They also re-arm a liveness timer for the indexed flow. Packet-sampling reasons are consumed with no other effect.

The block keeps an internal table of per-flow timers, indexed by the low bits of the flow index. A flow port marks a slot present or absent. A one-pulse-per-second tick starts a sweep state machine that visits one slot per cycle. On each visit it decrements the slot's timer. When a timer reaches zero, the block emits a one-cycle expiry event and frees the slot. A combinational query port reads back any slot.

The sweep machine has two states. `SW_IDLE` waits for a tick. `SW_RUN` steps a slot pointer from 0 to DEPTH-1. Its transitions are:
- START: `SW_IDLE` to `SW_RUN` on a tick, with the pointer at 0.
- STEP: `SW_RUN` to `SW_RUN`, with the pointer incremented.
- CHAIN: at the last slot, when a tick is pending or arriving, the machine stays in `SW_RUN` and the pointer returns to 0.
- DONE: at the last slot with no tick pending, `SW_RUN` to `SW_IDLE`.

Top module: `rx_reason_keepalive`

## Requirements
- R1: The flow index is descriptor bits [13:0]. The timer slot is the low log2(DEPTH) bits of that index. The reason code is bits [18:14].
- R2: Descriptor bits [31:19] have no effect on the decision or on any timer.
- R3: Reason codes 0x13, 0x14 and 0x15 are keepalives. The frame is consumed (`dec_deliver`=0). A present slot has its timer set to KA_SECS (30 by default).
- R4: Reason code 0x1B is sampling. The frame is consumed and no timer changes.
- R5: Every other reason code delivers the frame (`dec_deliver`=1) and changes no timer.
- R6: A keepalive whose slot is absent changes nothing. The slot stays absent and its timer reads 0.
- R7: A flow install (`flow_set_add`=1) makes the slot present with timer KA_SECS. A removal makes it absent with timer 0. A present slot never reads timer 0 or more than KA_SECS.
- R8: Each tick decrements every present timer by exactly one. The sweep takes one slot per cycle and finishes within DEPTH+1 cycles of the tick.
- R9: A timer that reaches zero raises `exp_valid` for one cycle, with `exp_slot` set to that slot. The slot becomes absent.
- R10: A keepalive that hits a slot in the same cycle as that slot's sweep visit wins. The timer reloads to KA_SECS and no expiry occurs.
- R11: Reset state:
  - During reset, `desc_ready` is 0.
  - From the first clock after reset, `desc_ready` is 1.
  - After reset, all slots are absent, and `dec_valid` and `exp_valid` are 0.
- R12: `dec_valid` pulses exactly in the cycle after a descriptor handshake, and at no other time.
- R13: A tick that arrives during a sweep is held. A second full sweep follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor word valid |
| desc_ready | output | 1 | Descriptor accepted when high |
| desc_word | input | 32 | Receive descriptor word |
| dec_valid | output | 1 | Decision valid, one cycle after a handshake |
| dec_deliver | output | 1 | 1 = deliver to host, 0 = consume |
| flow_set_valid | input | 1 | Flow install/remove request |
| flow_set_add | input | 1 | 1 = install, 0 = remove |
| flow_set_slot | input | log2(DEPTH) | Slot of install/remove |
| sec_tick | input | 1 | One-second pulse |
| exp_valid | output | 1 | Expiry event |
| exp_slot | output | log2(DEPTH) | Slot that expired |
| qry_slot | input | log2(DEPTH) | Slot to read |
| qry_present | output | 1 | Slot holds a flow |
| qry_timer | output | log2(KA_SECS+1) | Remaining seconds of the slot |

## Verification
The assertions assume a particular input discipline:
- `sec_tick` is a single-cycle pulse.
- An install or removal never targets the same slot, in the same cycle, as a keepalive the bench is checking.

Under this discipline, a present slot's timer always lies between 1 and KA_SECS, and every expiry leaves its slot absent. The stimulus drives every input on the falling edge. It issues flow operations only while no descriptor is in flight. It places the single refresh-versus-expiry collision on purpose, at the known cycle in which the sweep visits that slot.

// File: rtl/fkc_pkg.sv
package fkc_pkg;
    localparam int DESC_W  = 32;
    localparam int IDX_W   = 14;
    localparam int RSN_LSB = 14;
    localparam int RSN_W   = 5;

    localparam logic [RSN_W-1:0] RSN_KA_OLD  = 5'h13;
    localparam logic [RSN_W-1:0] RSN_KA_NEW  = 5'h14;
    localparam logic [RSN_W-1:0] RSN_KA_DUP  = 5'h15;
    localparam logic [RSN_W-1:0] RSN_SAMPLE  = 5'h1B;

    typedef enum logic [1:0] {
        KIND_PASS,
        KIND_KEEPALIVE,
        KIND_SAMPLE
    } frame_kind_e;

    typedef enum logic {
        SW_IDLE,
        SW_RUN
    } sweep_state_e;
endpackage

// File: rtl/fkc_desc_decode.sv
module fkc_desc_decode
    import fkc_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic [DESC_W-1:0] word,
    output frame_kind_e       kind,
    output logic [SLOT_W-1:0] slot
);
    logic [RSN_W-1:0] reason;
    logic             unused_fields;

    assign reason        = word[RSN_LSB +: RSN_W];
    assign slot          = word[SLOT_W-1:0];
    assign unused_fields = ^{word[DESC_W-1:RSN_LSB+RSN_W], word[IDX_W-1:SLOT_W]};

    always_comb begin
        unique case (reason)
            RSN_KA_OLD, RSN_KA_NEW, RSN_KA_DUP: kind = KIND_KEEPALIVE;
            RSN_SAMPLE:                         kind = KIND_SAMPLE;
            default:                            kind = KIND_PASS;
        endcase
    end
endmodule

// File: rtl/fkc_sweep_fsm.sv
module fkc_sweep_fsm
    import fkc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    output logic                     sweep_en,
    output logic [$clog2(DEPTH)-1:0] sweep_slot
);
    localparam int                SLOT_W = $clog2(DEPTH);
    localparam logic [SLOT_W-1:0] LAST   = SLOT_W'(DEPTH - 1);

    sweep_state_e      state_q, state_d;
    logic [SLOT_W-1:0] ptr_q, ptr_d;
    logic              pend_q, pend_d;

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        pend_d  = pend_q;
        unique case (state_q)
            SW_IDLE: begin
                if (tick) begin
                    state_d = SW_RUN;
                    ptr_d   = '0;
                end
            end
            SW_RUN: begin
                if (ptr_q == LAST) begin
                    ptr_d = '0;
                    if (pend_q || tick) begin
                        state_d = SW_RUN;
                        pend_d  = 1'b0;
                    end else begin
                        state_d = SW_IDLE;
                    end
                end else begin
                    ptr_d = SLOT_W'(ptr_q + 1'b1);
                    if (tick) pend_d = 1'b1;
                end
            end
            default: state_d = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            ptr_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        sweep_en   = (state_q == SW_RUN);
        sweep_slot = ptr_q;
    end
endmodule

// File: rtl/fkc_timer_table.sv
module fkc_timer_table #(
    parameter int DEPTH   = 16,
    parameter int KA_SECS = 30,
    parameter int SLOT_W  = $clog2(DEPTH),
    parameter int TMR_W   = $clog2(KA_SECS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              set_add,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic              ref_en,
    input  logic [SLOT_W-1:0] ref_slot,
    input  logic              sweep_en,
    input  logic [SLOT_W-1:0] sweep_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_present,
    output logic [TMR_W-1:0]  rd_timer,
    output logic              exp_valid,
    output logic [SLOT_W-1:0] exp_slot,
    output logic [DEPTH-1:0]  live
);
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(KA_SECS);

    logic [TMR_W-1:0] tmr_q [DEPTH];
    logic [DEPTH-1:0] live_q;
    logic             sweep_hits_zero;

    // Expiry only when neither a flow operation nor a keepalive touches the slot
    assign sweep_hits_zero = sweep_en && live_q[sweep_slot]
                          && (tmr_q[sweep_slot] <= TMR_W'(1))
                          && !(set_en && set_slot == sweep_slot)
                          && !(ref_en && ref_slot == sweep_slot);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            for (int i = 0; i < DEPTH; i++) tmr_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (set_en && set_slot == SLOT_W'(i)) begin
                    live_q[i] <= set_add;
                    tmr_q[i]  <= set_add ? RELOAD : '0;
                end else if (ref_en && ref_slot == SLOT_W'(i) && live_q[i]) begin
                    tmr_q[i] <= RELOAD;
                end else if (sweep_en && sweep_slot == SLOT_W'(i) && live_q[i]) begin
                    if (tmr_q[i] <= TMR_W'(1)) begin
                        tmr_q[i]  <= '0;
                        live_q[i] <= 1'b0;
                    end else begin
                        tmr_q[i] <= TMR_W'(tmr_q[i] - 1'b1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_slot  <= '0;
        end else begin
            exp_valid <= sweep_hits_zero;
            exp_slot  <= sweep_slot;
        end
    end

    assign rd_present = live_q[rd_slot];
    assign rd_timer   = tmr_q[rd_slot];
    assign live       = live_q;
endmodule

// File: rtl/rx_reason_keepalive.sv
module rx_reason_keepalive
    import fkc_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int KA_SECS = 30,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int TMR_W  = $clog2(KA_SECS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [31:0]       desc_word,
    output logic              dec_valid,
    output logic              dec_deliver,
    input  logic              flow_set_valid,
    input  logic              flow_set_add,
    input  logic [SLOT_W-1:0] flow_set_slot,
    input  logic              sec_tick,
    output logic              exp_valid,
    output logic [SLOT_W-1:0] exp_slot,
    input  logic [SLOT_W-1:0] qry_slot,
    output logic              qry_present,
    output logic [TMR_W-1:0]  qry_timer
);
    frame_kind_e       kind;
    logic [SLOT_W-1:0] desc_slot;
    logic              accept;
    logic              refresh_en;
    logic              sweep_en;
    logic [SLOT_W-1:0] sweep_slot;
    logic [DEPTH-1:0]  slot_live;
    logic              ready_q;

    fkc_desc_decode #(.SLOT_W(SLOT_W)) u_dec (
        .word (desc_word),
        .kind (kind),
        .slot (desc_slot)
    );

    assign accept     = desc_valid && ready_q;
    assign refresh_en = accept && (kind == KIND_KEEPALIVE);

    fkc_sweep_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (sec_tick),
        .sweep_en   (sweep_en),
        .sweep_slot (sweep_slot)
    );

    fkc_timer_table #(
        .DEPTH   (DEPTH),
        .KA_SECS (KA_SECS),
        .SLOT_W  (SLOT_W),
        .TMR_W   (TMR_W)
    ) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (flow_set_valid),
        .set_add    (flow_set_add),
        .set_slot   (flow_set_slot),
        .ref_en     (refresh_en),
        .ref_slot   (desc_slot),
        .sweep_en   (sweep_en),
        .sweep_slot (sweep_slot),
        .rd_slot    (qry_slot),
        .rd_present (qry_present),
        .rd_timer   (qry_timer),
        .exp_valid  (exp_valid),
        .exp_slot   (exp_slot),
        .live       (slot_live)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q     <= 1'b0;
            dec_valid   <= 1'b0;
            dec_deliver <= 1'b0;
        end else begin
            ready_q     <= 1'b1;
            dec_valid   <= accept;
            dec_deliver <= (kind == KIND_PASS);
        end
    end

    assign desc_ready = ready_q;
endmodule

// File: rtl/fkc_checker.sv
module fkc_checker #(
    parameter int DEPTH   = 16,
    parameter int KA_SECS = 30,
    parameter int SLOT_W  = 4,
    parameter int TMR_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic [31:0]       desc_word,
    input logic              dec_valid,
    input logic              dec_deliver,
    input logic              exp_valid,
    input logic [SLOT_W-1:0] exp_slot,
    input logic              qry_present,
    input logic [TMR_W-1:0]  qry_timer,
    input logic              sweep_en,
    input logic [DEPTH-1:0]  live
);
    logic hs;
    logic [4:0] rsn;
    assign hs  = desc_valid && desc_ready;
    assign rsn = desc_word[18:14];

    assert_decision_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> dec_valid);
    assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> !dec_valid);
    assert_keepalive_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && (rsn == 5'h13 || rsn == 5'h14 || rsn == 5'h15)) |=> !dec_deliver);
    assert_sample_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && rsn == 5'h1B) |=> !dec_deliver);
    assert_expiry_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exp_valid |-> (!live[exp_slot] && $past(sweep_en)));
    assert_timer_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        qry_present |-> (qry_timer != '0 && qry_timer <= TMR_W'(KA_SECS)));
    assert_absent_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_present |-> (qry_timer == '0));
    assert_ready_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |=> desc_ready);
endmodule

bind rx_reason_keepalive fkc_checker #(
    .DEPTH   (DEPTH),
    .KA_SECS (KA_SECS),
    .SLOT_W  (SLOT_W),
    .TMR_W   (TMR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_valid  (desc_valid),
    .desc_ready  (desc_ready),
    .desc_word   (desc_word),
    .dec_valid   (dec_valid),
    .dec_deliver (dec_deliver),
    .exp_valid   (exp_valid),
    .exp_slot    (exp_slot),
    .qry_present (qry_present),
    .qry_timer   (qry_timer),
    .sweep_en    (sweep_en),
    .live        (slot_live)
);

// File: tb/rx_reason_keepalive_tb_top.sv
`timescale 1ns/1ps
module rx_reason_keepalive_tb_top;
    localparam int DEPTH = 16;
    localparam int KA    = 30;
    localparam int SW    = 4;
    localparam int TW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_valid = 1'b0;
    logic          desc_ready;
    logic [31:0]   desc_word = '0;
    logic          dec_valid, dec_deliver;
    logic          flow_set_valid = 1'b0, flow_set_add = 1'b0;
    logic [SW-1:0] flow_set_slot = '0;
    logic          sec_tick = 1'b0;
    logic          exp_valid;
    logic [SW-1:0] exp_slot;
    logic [SW-1:0] qry_slot = '0;
    logic          qry_present;
    logic [TW-1:0] qry_timer;

    always #4 clk = ~clk;

    rx_reason_keepalive #(.DEPTH(DEPTH), .KA_SECS(KA)) dut_i (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_word(desc_word), .dec_valid(dec_valid), .dec_deliver(dec_deliver),
        .flow_set_valid(flow_set_valid), .flow_set_add(flow_set_add),
        .flow_set_slot(flow_set_slot), .sec_tick(sec_tick), .exp_valid(exp_valid),
        .exp_slot(exp_slot), .qry_slot(qry_slot), .qry_present(qry_present),
        .qry_timer(qry_timer)
    );

    int  checks = 0, errors = 0;
    int  m_tmr [DEPTH];
    bit  m_live [DEPTH];
    int  exp_want [DEPTH];
    int  exp_seen [DEPTH];

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    always @(negedge clk) if (rst_n && exp_valid) exp_seen[exp_slot]++;

    task automatic check_slots(string req);
        for (int s = 0; s < DEPTH; s++) begin
            @(negedge clk);
            qry_slot = SW'(s);
            #1;
            chk(qry_present == m_live[s], req, int'(qry_present), int'(m_live[s]));
            chk(int'(qry_timer) == m_tmr[s], req, int'(qry_timer), m_tmr[s]);
        end
    endtask

    task automatic check_expiry(string req);
        for (int s = 0; s < DEPTH; s++)
            chk(exp_seen[s] == exp_want[s], req, exp_seen[s], exp_want[s]);
    endtask

    task automatic flow_op(int slot, bit add);
        @(negedge clk);
        flow_set_valid = 1'b1; flow_set_add = add; flow_set_slot = SW'(slot);
        @(negedge clk);
        flow_set_valid = 1'b0;
        m_live[slot] = add;
        m_tmr[slot]  = add ? KA : 0;
    endtask

    function automatic bit is_ka(int code);
        return code == 'h13 || code == 'h14 || code == 'h15;
    endfunction

    function automatic logic [31:0] mk(int code, int slot, int salt);
        logic [31:0] w;
        w = '0;
        w[31:19] = 13'(salt * 1237 + 5);
        w[18:14] = 5'(code);
        w[13:4]  = 10'(salt * 37 + 1);
        w[3:0]   = 4'(slot);
        return w;
    endfunction

    task automatic model_sweep();
        for (int s = 0; s < DEPTH; s++) if (m_live[s]) begin
            m_tmr[s]--;
            if (m_tmr[s] == 0) begin m_live[s] = 0; exp_want[s]++; end
        end
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (DEPTH + 2) @(negedge clk);
        model_sweep();
    endtask

    task automatic send(int code, int slot, int salt, string req);
        bit want;
        @(negedge clk);
        desc_valid = 1'b1; desc_word = mk(code, slot, salt);
        @(negedge clk);
        desc_valid = 1'b0;
        want = !(is_ka(code) || code == 'h1B);
        chk(dec_valid == 1'b1, req, int'(dec_valid), 1);
        chk(dec_deliver == want, req, int'(dec_deliver), int'(want));
        if (is_ka(code) && m_live[slot]) m_tmr[slot] = KA;
        @(negedge clk);
        chk(dec_valid == 1'b0, "R12", int'(dec_valid), 0);
        qry_slot = SW'(slot);
        #1;
        chk(qry_present == m_live[slot], req, int'(qry_present), int'(m_live[slot]));
        chk(int'(qry_timer) == m_tmr[slot], req, int'(qry_timer), m_tmr[slot]);
    endtask

    initial begin
        for (int s = 0; s < DEPTH; s++) begin
            m_tmr[s] = 0; m_live[s] = 0; exp_want[s] = 0; exp_seen[s] = 0;
        end
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(desc_ready == 1'b0, "R11", int'(desc_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(desc_ready == 1'b1, "R11", int'(desc_ready), 1);
        chk(dec_valid == 1'b0, "R11", int'(dec_valid), 0);
        chk(exp_valid == 1'b0, "R11", int'(exp_valid), 0);
        check_slots("R11");

        // R7: install every slot, remove slot 3
        for (int s = 0; s < DEPTH; s++) flow_op(s, 1'b1);
        check_slots("R7");
        flow_op(3, 1'b0);
        check_slots("R7");

        // R8: one tick takes every present timer down by one
        tick();
        check_slots("R8");

        // R1 R2 R3 R4 R5 R6: sweep all reason codes, salted upper bits
        for (int c = 0; c < 32; c++) begin
            string r;
            if (is_ka(c)) r = (m_live[c % DEPTH]) ? "R3" : "R6";
            else if (c == 'h1B) r = "R4";
            else r = "R5";
            send(c, c % DEPTH, c, r);
            // R2: same code and slot with different ignored bits
            send(c, c % DEPTH, c + 101, "R2");
        end
        // R1: slot comes from the low index bits only (upper index bits salted)
        check_slots("R1");

        // R13: second tick during a running sweep
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (3) @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (2 * DEPTH + 4) @(negedge clk);
        model_sweep(); model_sweep();
        check_slots("R13");

        // R10: refresh on the very cycle slot 5 would expire
        for (int s = 0; s < DEPTH; s++) flow_op(s, 1'b0);
        flow_op(5, 1'b1);
        flow_op(6, 1'b1);
        for (int k = 0; k < KA - 1; k++) tick();
        check_slots("R8");
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (5) @(negedge clk);
        desc_valid = 1'b1; desc_word = mk('h14, 5, 77);
        @(negedge clk);
        desc_valid = 1'b0;
        chk(dec_deliver == 1'b0, "R10", int'(dec_deliver), 0);
        repeat (DEPTH) @(negedge clk);
        model_sweep();
        exp_want[5]--; m_live[5] = 1; m_tmr[5] = KA;
        check_slots("R10");
        check_expiry("R9");

        // R9: let slot 5 run out
        for (int k = 0; k < KA; k++) tick();
        check_slots("R9");
        check_expiry("R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule